// File: doc/BRIEF.md
# Delayed Branch Fetch Sequencer

This block is the next-address logic of an instruction fetch unit for a pipeline in which every branch has one architectural delay slot. It owns the fetch address register and, every cycle, presents the address to fetch together with a flag saying whether that fetch is a real instruction or a bubble. A decode stage reports, one cycle after each fetch, whether the instruction just fetched is a conditional branch, along with its 16-bit signed offset and whether the branch's source register reads as zero.

The instruction that follows a branch is always fetched and always executes. A branch whose register is zero is taken: after the delay slot the sequencer inserts a fixed number of bubble cycles, marked invalid and flagged as a stall, and then fetches the target. A branch whose register is non-zero falls through with no bubble at all. A branch that sits in a delay slot is not acted on; it is reported on a flag so the surrounding logic can treat it as a no-op.

Top module: `delay_slot_fetch_seq`

## Requirements
- R1: While reset is low and in the first cycle after it, `fetch_pc_o` equals `RESET_PC` with `fetch_valid_o`=1, `stall_o`=0 and `slot_branch_o`=0.
- R2: When no branch is acted on and no bubble is pending, each valid fetch address is the previous fetch address plus 4.
- R3: The target of a taken branch is its own address plus 4 plus the offset, the offset being widened to 32 bits by copying its top bit (bit 15) into bits 31..16, unscaled, with the sum taken modulo 2^32.
- R4: In the cycle a branch is reported on `br_valid_i`, the fetch is the branch address plus 4 (the delay slot) and is valid, whatever the branch outcome.
- R5: After a taken branch, exactly `STALLS` cycles (default 2) follow the delay-slot fetch with `fetch_valid_o`=0 and `stall_o`=1, and the next cycle fetches the target with `fetch_valid_o`=1 and `stall_o`=0.
- R6: After a not-taken branch, the fetch in the next cycle is the branch address plus 8, valid and with no stall.
- R7: A reported branch is taken exactly when `src_zero_i`=1.
- R8: A branch reported while the decode stage holds a delay slot does not alter the fetch sequence, and `slot_branch_o` is 1 in that same cycle (combinationally from `br_valid_i`).
- R9: `br_valid_i` in a cycle where the decode stage holds no valid instruction (the first cycle after reset, and the cycles following a bubble) is ignored and does not raise `slot_branch_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| br_valid_i | input | 1 | The instruction fetched in the previous cycle is a conditional branch |
| br_imm_i | input | IMM_W (16) | Signed byte offset of that branch |
| src_zero_i | input | 1 | The branch's source register equals zero (branch taken) |
| fetch_pc_o | output | ADDR_W (32) | Address to fetch this cycle |
| fetch_valid_o | output | 1 | This cycle's fetch is a real instruction |
| stall_o | output | 1 | This cycle is a bubble after a taken branch |
| slot_branch_o | output | 1 | A branch was reported in a delay slot and is ignored |

## Verification
The main function is driven with a sweep of offsets (zero, small positive and negative, the extreme positive and negative values and every single-bit value) crossed with both branch outcomes, which separates a correct target sum and sign extension from scaled, unextended or zero-extended variants and separates the taken and fall-through paths. Each combination is repeated with and without a second branch in the delay slot, which tells apart a sequencer that ignores slot branches from one that acts on them. Branches are also offered during bubble cycles and right after reset, so that only branches on valid decoded instructions can move the fetch address.

// File: rtl/fseq_pkg.sv
// Package: shared constants of the delayed-branch fetch sequencer.
// Assumes fixed-size 4-byte instructions.
package fseq_pkg;
    localparam int unsigned STEP_BYTES = 4;
endpackage

// File: rtl/fseq_addr.sv
// Module: fseq_addr
// Computes the sequential fetch address and the branch target.
// Assumes ADDR_W > IMM_W; the offset is a signed byte offset, not scaled.
module fseq_addr #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IMM_W  = 16
) (
    input  logic [ADDR_W-1:0] fetch_pc_i,
    input  logic [ADDR_W-1:0] dec_pc_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic [ADDR_W-1:0] seq_pc_o,
    output logic [ADDR_W-1:0] target_o
);
    localparam int unsigned EXT_W = ADDR_W - IMM_W;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(fseq_pkg::STEP_BYTES);

    logic [ADDR_W-1:0] imm_ext;

    // Widen the offset by copying its sign bit.
    always_comb imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};

    // Next sequential fetch and target relative to the branch's successor.
    always_comb begin
        seq_pc_o = fetch_pc_i + STEP;
        target_o = dec_pc_i + STEP + imm_ext;
    end
endmodule

// File: rtl/fseq_slot.sv
// Module: fseq_slot
// Tracks the instruction now in decode (its address, whether it is real,
// whether it is a delay slot) and decides whether a reported branch is acted on.
// Assumes br_valid_i refers to the fetch of the previous cycle.
module fseq_slot #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_pc_i,
    input  logic              fetch_valid_i,
    input  logic              br_valid_i,
    output logic [ADDR_W-1:0] dec_pc_o,
    output logic              accept_o,
    output logic              slot_branch_o
);
    logic dec_valid_q;
    logic dec_slot_q;

    // Record what moves from fetch into decode each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_pc_o    <= '0;
            dec_valid_q <= 1'b0;
            dec_slot_q  <= 1'b0;
        end else begin
            dec_pc_o    <= fetch_pc_i;
            dec_valid_q <= fetch_valid_i;
            dec_slot_q  <= accept_o;
        end
    end

    // A branch counts only on a real, non-slot decoded instruction.
    always_comb begin
        accept_o      = br_valid_i & dec_valid_q & ~dec_slot_q;
        slot_branch_o = br_valid_i & dec_valid_q &  dec_slot_q;
    end

    // R8: a flagged slot branch always follows an accepted branch.
    assert_slot_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        slot_branch_o |-> $past(accept_o));
endmodule

// File: rtl/fseq_stall.sv
// Module: fseq_stall
// Counts the bubble cycles inserted after a taken branch.
// Assumes load_i never arrives while the counter is busy.
module fseq_stall #(
    parameter int unsigned STALLS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic busy_o
);
    localparam int unsigned CNT_W = (STALLS < 1) ? 1 : $clog2(STALLS + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(STALLS);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Load on a taken branch, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load_i)        cnt_q <= LOAD_VAL;
        else if (cnt_q != '0)   cnt_q <= cnt_q - ONE;
    end

    // Busy while bubbles remain.
    always_comb busy_o = (cnt_q != '0);

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD_VAL);
    assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !load_i) |=> (cnt_q == $past(cnt_q) - ONE));
    assert_no_load_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !load_i);
endmodule

// File: rtl/delay_slot_fetch_seq.sv
// Module: delay_slot_fetch_seq (top)
// Next-PC sequencer for a pipeline with one branch delay slot. The slot is
// always fetched; a taken branch (source register zero) adds STALLS bubbles
// before its target, a not-taken branch costs nothing. Branches in a delay
// slot are ignored and flagged.
// Assumes the decode stage reports branches one cycle after their fetch.
module delay_slot_fetch_seq #(
    parameter int unsigned      ADDR_W   = 32,
    parameter int unsigned      IMM_W    = 16,
    parameter int unsigned      STALLS   = 2,
    parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid_i,
    input  logic [IMM_W-1:0]  br_imm_i,
    input  logic              src_zero_i,
    output logic [ADDR_W-1:0] fetch_pc_o,
    output logic              fetch_valid_o,
    output logic              stall_o,
    output logic              slot_branch_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(fseq_pkg::STEP_BYTES);

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] seq_pc;
    logic [ADDR_W-1:0] target;
    logic [ADDR_W-1:0] dec_pc;
    logic              accept;
    logic              take;
    logic              busy;

    fseq_addr #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_addr (
        .fetch_pc_i (pc_q),
        .dec_pc_i   (dec_pc),
        .imm_i      (br_imm_i),
        .seq_pc_o   (seq_pc),
        .target_o   (target)
    );

    fseq_slot #(.ADDR_W(ADDR_W)) u_slot (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_pc_i    (pc_q),
        .fetch_valid_i (fetch_valid_o),
        .br_valid_i    (br_valid_i),
        .dec_pc_o      (dec_pc),
        .accept_o      (accept),
        .slot_branch_o (slot_branch_o)
    );

    fseq_stall #(.STALLS(STALLS)) u_stall (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (take),
        .busy_o (busy)
    );

    // Taken decision: accepted branch whose register reads zero.
    always_comb take = accept & src_zero_i;

    // Fetch address: jump to target, hold during bubbles, else step.
    always_ff @(posedge clk) begin
        if (!rst_n)     pc_q <= RESET_PC;
        else if (take)  pc_q <= target;
        else if (!busy) pc_q <= seq_pc;
    end

    // Drive the fetch outputs.
    always_comb begin
        fetch_pc_o    = pc_q;
        fetch_valid_o = ~busy;
        stall_o       = busy;
    end

    // R4: the delay slot is a real fetch when a branch is acted on.
    assert_slot_fetched_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> fetch_valid_o);
    // R6: fall-through continues at the next word with no bubble.
    assert_fallthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !src_zero_i) |=> (fetch_valid_o && fetch_pc_o == $past(fetch_pc_o) + STEP));

    generate
        if (STALLS > 0) begin : g_stall_chk
            // R5: a taken branch is followed by a bubble.
            assert_taken_bubble_R5: assert property (@(posedge clk) disable iff (!rst_n)
                take |=> (stall_o && !fetch_valid_o));
        end else begin : g_nostall_chk
            // R5: with no bubbles the target follows the slot directly.
            assert_taken_direct_R5: assert property (@(posedge clk) disable iff (!rst_n)
                take |=> fetch_valid_o);
        end
    endgenerate
endmodule

// File: tb/tb_delay_slot_fetch_seq.sv
`timescale 1ns/1ps
module tb_delay_slot_fetch_seq;
    localparam int unsigned S    = 2;
    localparam logic [31:0] RPC  = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid_i = 1'b0;
    logic [15:0] br_imm_i = '0;
    logic        src_zero_i = 1'b0;
    logic [31:0] fetch_pc_o;
    logic        fetch_valid_o, stall_o, slot_branch_o;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_next;

    delay_slot_fetch_seq #(.STALLS(S), .RESET_PC(RPC)) dut (
        .clk(clk), .rst_n(rst_n), .br_valid_i(br_valid_i), .br_imm_i(br_imm_i),
        .src_zero_i(src_zero_i), .fetch_pc_o(fetch_pc_o), .fetch_valid_o(fetch_valid_o),
        .stall_o(stall_o), .slot_branch_o(slot_branch_o)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One branch at address a: offset imm, outcome zero, optional slot branch.
    task automatic run_branch(input logic [15:0] imm, input bit zero, input bit sbr);
        logic [31:0] a, tgt;
        @(negedge clk);
        br_valid_i = 1'b0;
        a = fetch_pc_o;
        chk(fetch_valid_o && !stall_o, "R2 valid sequential fetch", {31'd0, fetch_valid_o}, 32'd1);
        chk(a == exp_next, "R2 address plus 4", a, exp_next);
        tgt = a + 32'd4 + {{16{imm[15]}}, imm};
        @(negedge clk);
        br_valid_i = 1'b1; br_imm_i = imm; src_zero_i = zero;
        #1;
        chk(fetch_valid_o && fetch_pc_o == a + 32'd4, "R4 delay slot fetched", fetch_pc_o, a + 32'd4);
        chk(!slot_branch_o, "R8 no flag on normal branch", {31'd0, slot_branch_o}, 32'd0);
        @(negedge clk);
        br_valid_i = sbr; br_imm_i = 16'h0400; src_zero_i = 1'b1;
        #1;
        chk(slot_branch_o == sbr, "R8 slot branch flag", {31'd0, slot_branch_o}, {31'd0, sbr});
        if (zero) begin
            chk(!fetch_valid_o && stall_o, "R5 R7 bubble after taken", {30'd0, stall_o, fetch_valid_o}, 32'd2);
            for (int i = 1; i < int'(S); i++) begin
                @(negedge clk);
                br_valid_i = 1'b1; src_zero_i = 1'b1;
                #1;
                chk(!slot_branch_o, "R9 no flag in bubble", {31'd0, slot_branch_o}, 32'd0);
                chk(!fetch_valid_o && stall_o, "R5 bubble count", {30'd0, stall_o, fetch_valid_o}, 32'd2);
            end
            @(negedge clk);
            br_valid_i = 1'b1; src_zero_i = 1'b1;
            #1;
            chk(!slot_branch_o, "R9 no flag after bubble", {31'd0, slot_branch_o}, 32'd0);
            chk(fetch_valid_o && !stall_o, "R5 target valid", {30'd0, stall_o, fetch_valid_o}, 32'd1);
            chk(fetch_pc_o == tgt, "R3 target address", fetch_pc_o, tgt);
            exp_next = tgt + 32'd4;
        end else begin
            chk(fetch_valid_o && !stall_o && fetch_pc_o == a + 32'd8, "R6 R7 fall-through", fetch_pc_o, a + 32'd8);
            exp_next = a + 32'd12;
            if (sbr) begin
                @(negedge clk);
                br_valid_i = 1'b0;
                chk(fetch_valid_o && fetch_pc_o == a + 32'd12, "R8 slot branch ignored", fetch_pc_o, a + 32'd12);
                exp_next = a + 32'd16;
            end
        end
    endtask

    initial begin
        logic [15:0] imms [8];
        imms = '{16'h0000, 16'h0004, 16'hFFFC, 16'h7FFC, 16'h8000, 16'h1000, 16'hFFF0, 16'h0100};
        repeat (3) @(negedge clk);
        chk(fetch_pc_o == RPC && fetch_valid_o && !stall_o && !slot_branch_o, "R1 in reset", fetch_pc_o, RPC);
        rst_n = 1'b1;
        chk(fetch_pc_o == RPC && fetch_valid_o && !stall_o, "R1 after reset", fetch_pc_o, RPC);
        br_valid_i = 1'b1; src_zero_i = 1'b1; br_imm_i = 16'h2000;
        #1;
        chk(!slot_branch_o, "R9 branch right after reset", {31'd0, slot_branch_o}, 32'd0);
        @(negedge clk);
        br_valid_i = 1'b0;
        chk(fetch_pc_o == RPC + 32'd4 && fetch_valid_o && !stall_o, "R9 ignored after reset", fetch_pc_o, RPC + 32'd4);
        exp_next = RPC + 32'd8;
        foreach (imms[k])
            for (int z = 0; z < 2; z++)
                for (int sb = 0; sb < 2; sb++)
                    run_branch(imms[k], z[0], sb[0]);
        for (int b = 0; b < 16; b++) run_branch(16'(1 << b), 1'b1, 1'b0);
        @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #200000;
        fails++; checks++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule